// File: doc/BRIEF.md
# Host-Firmware Mailbox With Ownership Semaphore

This block is a single-slot message mailbox between a host CPU and the embedded firmware processor of a USB host controller. The host reaches it through a simple register bus with separate read and write strobes, an address and a 32-bit data word. The firmware has a dedicated port. On this port it posts outbound messages to the host, consumes the inbound message the host left for it, and reports a hang. One interrupt line goes to each side.

A message word packs an 8-bit command code in bits 31:24 with a 24-bit payload in bits 23:0. A two-bit owner semaphore guards the slot. A party claims the slot by writing its own code while the slot is free, then reads the owner back to confirm the claim. Interrupts are released by enable bits in the command register, one bit per destination plus a global enable. A status register holds a sticky firmware-hang flag, cleared by writing one to it, and the enable that gates the host interrupt.

Top module: `hfw_mailbox`

## Requirements
- R1: While reset is low, every register clears. Reads of the command (0xE4), inbound (0xE8), outbound (0xEC), owner (0xF0) and status (0x428) registers then return 0, and both interrupt outputs are low.
- R2: The owner field is bits 1:0 of 0xF0, coded 0 = free, 1 = firmware, 2 = host. Writing 1 or 2 takes effect only while the owner is 0. Writing 1 or 2 while another owner holds the slot leaves the owner unchanged, and writing code 3 is ignored.
- R3: Writing 0 to the owner register always frees the slot, whoever holds it.
- R4: A host write to 0xE8 is stored only when its command field matches the current owner. Codes 128 (ACK) and 129 (NAK) need owner 1. Every other code needs owner 2. A write that does not match leaves the register unchanged.
- R5: The firmware port presents the stored inbound word unpacked: fw_in_cmd is bits 31:24 and fw_in_data is bits 23:0.
- R6: The command register keeps bits 31 (global), 30 (host controller), 29 (SMI), 28 (PME) and 27 (firmware); its other bits read 0. irq_fw is high whenever bits 31 and 27 are both set.
- R7: A fw_consume pulse clears command bit 27 and leaves the other command bits as they were, so irq_fw falls one cycle later.
- R8: A fw_post pulse is accepted when the owner is not 2. An accepted post loads {fw_out_cmd, fw_out_data} into 0xEC, sets command bits 31 and 29, and sets the owner to 1. While the owner is 2, a post changes nothing.
- R9: irq_host is high when status bit 3 (SMI enable) is set and either command bits 31 and 29 are both set or the hang flag is set. It is never high while bit 3 is clear.
- R10: A fw_hang pulse sets status bit 1, and the bit then stays set. A host write with bit 1 = 1 clears it, while bit 1 = 0 leaves it. Bit 3 takes the written value, so writing back a value just read clears the flag and keeps the enable.
- R11: When fw_hang arrives in the same cycle as a host write that clears the hang flag, the flag stays set.
- R12: Reads of an unmapped address return 0, and writes to one change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe; data valid the next cycle |
| host_addr | input | ADDR_W (12) | Host register byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data |
| fw_post | input | 1 | Firmware posts an outbound message |
| fw_out_cmd | input | 8 | Command code of the posted message |
| fw_out_data | input | 24 | Payload of the posted message |
| fw_consume | input | 1 | Firmware has taken the inbound message |
| fw_hang | input | 1 | Firmware hang indication |
| fw_in_cmd | output | 8 | Command code of the stored inbound word |
| fw_in_data | output | 24 | Payload of the stored inbound word |
| irq_fw | output | 1 | Interrupt toward the firmware processor |
| irq_host | output | 1 | Interrupt toward the host |

## Verification
The assertions run on every cycle. They check that a held owner only stays put or returns to free, that a consume drops the firmware interrupt, that a hang pulse sets the sticky flag, that the host interrupt never rises without its enable, and that an accepted post with the enable set raises the host interrupt. The bench scenarios cover what needs a sequence of steps: the claim-and-readback rules, rejection of inbound words whose code does not match the owner, the unpacked view on the firmware side, the write-back clearing of the status register, the race between a hang and a clear, and unmapped addresses.

// File: rtl/hfw_mbox_pkg.sv
// Package: shared encodings for the host-firmware mailbox.
// Holds the owner codes, the response command codes, the index of each
// enable bit in the stored command field, and the status bit positions.
package hfw_mbox_pkg;

    localparam int OWN_W = 2;
    localparam logic [OWN_W-1:0] OWN_NONE = 2'd0;
    localparam logic [OWN_W-1:0] OWN_FW   = 2'd1;
    localparam logic [OWN_W-1:0] OWN_HOST = 2'd2;

    // Response codes that must travel with the firmware as owner
    localparam int RESP_ACK = 128;
    localparam int RESP_NAK = 129;

    // Command enable field: stored as the top EN_N bits of the word
    localparam int EN_N       = 5;
    localparam int EN_IDX_FW  = 0;   // word bit 27
    localparam int EN_IDX_PME = 1;   // word bit 28
    localparam int EN_IDX_SMI = 2;   // word bit 29
    localparam int EN_IDX_HC  = 3;   // word bit 30
    localparam int EN_IDX_GLB = 4;   // word bit 31

    // Status register bit positions
    localparam int STAT_HANG_BIT   = 1;
    localparam int STAT_SMI_EN_BIT = 3;

endpackage

// File: rtl/hfw_owner_sema.sv
// Module: ownership semaphore for the mailbox slot.
// Assumes: at most one host owner write per cycle; fw_take is only raised
// by the message block when the slot is not held by the host.
// A claim (firmware or host code) succeeds only from free, a release
// always succeeds, and an accepted firmware post makes the firmware owner.
module hfw_owner_sema
    import hfw_mbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr_own,
    input  logic [OWN_W-1:0] host_code,
    input  logic             fw_take,
    output logic [OWN_W-1:0] owner
);

    logic [OWN_W-1:0] owner_q;
    logic [OWN_W-1:0] owner_after_host;
    logic             claim_code;

    // Purpose: recognise the codes a party may claim with
    assign claim_code = (host_code == OWN_FW) || (host_code == OWN_HOST);

    // Purpose: apply the host write rules (release always, claim from free)
    always_comb begin
        owner_after_host = owner_q;
        if (host_wr_own) begin
            if (host_code == OWN_NONE) begin
                owner_after_host = OWN_NONE;
            end else if (claim_code && (owner_q == OWN_NONE)) begin
                owner_after_host = host_code;
            end
        end
    end

    // Purpose: hold the owner; a firmware post is applied after the host write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= OWN_NONE;
        end else if (fw_take) begin
            owner_q <= OWN_FW;
        end else begin
            owner_q <= owner_after_host;
        end
    end

    assign owner = owner_q;

endmodule

// File: rtl/hfw_msg_regs.sv
// Module: inbound and outbound message word registers.
// Assumes: the owner value given is the current (registered) owner.
// A host inbound write is stored only when its command code fits the owner:
// response codes need the firmware as owner, all others need the host.
// A firmware post is accepted whenever the host does not hold the slot.
module hfw_msg_regs
    import hfw_mbox_pkg::*;
#(
    parameter int CMD_W     = 8,
    parameter int PAYLOAD_W = 24,
    localparam int WORD_W   = CMD_W + PAYLOAD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr_in,
    input  logic [WORD_W-1:0]    host_wdata,
    input  logic [OWN_W-1:0]     owner,
    input  logic                 fw_post,
    input  logic [CMD_W-1:0]     fw_out_cmd,
    input  logic [PAYLOAD_W-1:0] fw_out_data,
    output logic                 post_accept,
    output logic [WORD_W-1:0]    in_word,
    output logic [WORD_W-1:0]    out_word
);

    logic [WORD_W-1:0] in_q;
    logic [WORD_W-1:0] out_q;
    logic [CMD_W-1:0]  wr_code;
    logic              wr_is_resp;
    logic              in_accept;

    // Purpose: pick out the command code of the host's inbound word
    assign wr_code    = host_wdata[WORD_W-1 -: CMD_W];
    assign wr_is_resp = (wr_code == CMD_W'(RESP_ACK)) || (wr_code == CMD_W'(RESP_NAK));

    // Purpose: accept an inbound word only when its code fits the owner
    assign in_accept = host_wr_in &&
                       (wr_is_resp ? (owner == OWN_FW) : (owner == OWN_HOST));

    // Purpose: accept a firmware post unless the host holds the slot
    assign post_accept = fw_post && (owner != OWN_HOST);

    // Purpose: inbound word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q <= '0;
        end else if (in_accept) begin
            in_q <= host_wdata;
        end
    end

    // Purpose: outbound word register, packed from the firmware fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (post_accept) begin
            out_q <= {fw_out_cmd, fw_out_data};
        end
    end

    assign in_word  = in_q;
    assign out_word = out_q;

endmodule

// File: rtl/hfw_ctrl_irq.sv
// Module: command enable bits, status register and interrupt outputs.
// Assumes: host_wen carries the top EN_N bits of the host write word.
// Firmware actions in a cycle are applied after a host write to the command
// register: a post sets global and SMI enables, a consume clears the
// firmware enable. The hang flag is sticky; a clear by the host loses to a
// hang arriving in the same cycle.
module hfw_ctrl_irq
    import hfw_mbox_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr_cmd,
    input  logic [EN_N-1:0] host_wen,
    input  logic            host_wr_stat,
    input  logic            host_hang_clr,
    input  logic            host_smi_en,
    input  logic            post_accept,
    input  logic            fw_consume,
    input  logic            fw_hang,
    output logic [EN_N-1:0] en,
    output logic            hang,
    output logic            smi_en,
    output logic            irq_fw,
    output logic            irq_host
);

    logic hang_q;
    logic smi_en_q;

    // One register per enable bit; the parameterised index picks its set/clear source
    for (genvar i = 0; i < EN_N; i++) begin : g_en
        logic bit_q;
        logic set_b;
        logic clr_b;

        // Purpose: firmware post sets the global and SMI enables
        assign set_b = post_accept && ((i == EN_IDX_GLB) || (i == EN_IDX_SMI));
        // Purpose: firmware consume clears the firmware enable
        assign clr_b = fw_consume && (i == EN_IDX_FW);

        // Purpose: hold one enable bit, firmware action over host write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (set_b) begin
                bit_q <= 1'b1;
            end else if (clr_b) begin
                bit_q <= 1'b0;
            end else if (host_wr_cmd) begin
                bit_q <= host_wen[i];
            end
        end

        assign en[i] = bit_q;
    end

    // Purpose: sticky hang flag, set wins over a write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hang_q <= 1'b0;
        end else if (fw_hang) begin
            hang_q <= 1'b1;
        end else if (host_wr_stat && host_hang_clr) begin
            hang_q <= 1'b0;
        end
    end

    // Purpose: host interrupt enable, plain read/write bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smi_en_q <= 1'b0;
        end else if (host_wr_stat) begin
            smi_en_q <= host_smi_en;
        end
    end

    // Purpose: level interrupts toward each side
    assign irq_fw   = en[EN_IDX_GLB] && en[EN_IDX_FW];
    assign irq_host = smi_en_q && ((en[EN_IDX_GLB] && en[EN_IDX_SMI]) || hang_q);

    assign hang   = hang_q;
    assign smi_en = smi_en_q;

endmodule

// File: rtl/hfw_mailbox.sv
// Module: top of the host-firmware mailbox.
// Decodes the host register bus, builds the registered read data, and ties
// together the owner semaphore, message registers and control/interrupt logic.
// Assumes: one host access per cycle; read data appears the cycle after host_rd.
module hfw_mailbox
    import hfw_mbox_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int CMD_W     = 8,
    parameter int PAYLOAD_W = 24,
    parameter logic [ADDR_W-1:0] OFS_CMD  = 12'h0E4,
    parameter logic [ADDR_W-1:0] OFS_IN   = 12'h0E8,
    parameter logic [ADDR_W-1:0] OFS_OUT  = 12'h0EC,
    parameter logic [ADDR_W-1:0] OFS_OWN  = 12'h0F0,
    parameter logic [ADDR_W-1:0] OFS_STAT = 12'h428,
    localparam int WORD_W = CMD_W + PAYLOAD_W,
    localparam int EN_LSB = WORD_W - EN_N
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [WORD_W-1:0]    host_wdata,
    output logic [WORD_W-1:0]    host_rdata,
    input  logic                 fw_post,
    input  logic [CMD_W-1:0]     fw_out_cmd,
    input  logic [PAYLOAD_W-1:0] fw_out_data,
    input  logic                 fw_consume,
    input  logic                 fw_hang,
    output logic [CMD_W-1:0]     fw_in_cmd,
    output logic [PAYLOAD_W-1:0] fw_in_data,
    output logic                 irq_fw,
    output logic                 irq_host
);

    logic              wr_cmd, wr_in, wr_own, wr_stat;
    logic [OWN_W-1:0]  owner_q;
    logic              post_accept;
    logic [WORD_W-1:0] in_word, out_word;
    logic [EN_N-1:0]   en_q;
    logic              hang_q, smi_en_q;
    logic [WORD_W-1:0] stat_word;
    logic [WORD_W-1:0] rd_mux;
    logic [WORD_W-1:0] rdata_q;

    // Purpose: write strobes per register
    assign wr_cmd  = host_wr && (host_addr == OFS_CMD);
    assign wr_in   = host_wr && (host_addr == OFS_IN);
    assign wr_own  = host_wr && (host_addr == OFS_OWN);
    assign wr_stat = host_wr && (host_addr == OFS_STAT);

    hfw_owner_sema u_sema (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr_own (wr_own),
        .host_code   (host_wdata[OWN_W-1:0]),
        .fw_take     (post_accept),
        .owner       (owner_q)
    );

    hfw_msg_regs #(
        .CMD_W     (CMD_W),
        .PAYLOAD_W (PAYLOAD_W)
    ) u_msg (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr_in  (wr_in),
        .host_wdata  (host_wdata),
        .owner       (owner_q),
        .fw_post     (fw_post),
        .fw_out_cmd  (fw_out_cmd),
        .fw_out_data (fw_out_data),
        .post_accept (post_accept),
        .in_word     (in_word),
        .out_word    (out_word)
    );

    hfw_ctrl_irq u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_wr_cmd   (wr_cmd),
        .host_wen      (host_wdata[WORD_W-1:EN_LSB]),
        .host_wr_stat  (wr_stat),
        .host_hang_clr (host_wdata[STAT_HANG_BIT]),
        .host_smi_en   (host_wdata[STAT_SMI_EN_BIT]),
        .post_accept   (post_accept),
        .fw_consume    (fw_consume),
        .fw_hang       (fw_hang),
        .en            (en_q),
        .hang          (hang_q),
        .smi_en        (smi_en_q),
        .irq_fw        (irq_fw),
        .irq_host      (irq_host)
    );

    // Purpose: assemble the status word from its two live bits
    always_comb begin
        stat_word = '0;
        stat_word[STAT_HANG_BIT]   = hang_q;
        stat_word[STAT_SMI_EN_BIT] = smi_en_q;
    end

    // Purpose: select read data by address, zero for unmapped
    always_comb begin
        case (host_addr)
            OFS_CMD:  rd_mux = {en_q, {EN_LSB{1'b0}}};
            OFS_IN:   rd_mux = in_word;
            OFS_OUT:  rd_mux = out_word;
            OFS_OWN:  rd_mux = {{(WORD_W-OWN_W){1'b0}}, owner_q};
            OFS_STAT: rd_mux = stat_word;
            default:  rd_mux = '0;
        endcase
    end

    // Purpose: register the read data on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (host_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign host_rdata = rdata_q;
    assign fw_in_cmd  = in_word[WORD_W-1 -: CMD_W];
    assign fw_in_data = in_word[PAYLOAD_W-1:0];

endmodule

// File: rtl/hfw_mailbox_chk.sv
// Module: assertion checker bound to the mailbox top.
// Observes ports and the owner/status state; drives nothing.
module hfw_mailbox_chk #(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] OFS_STAT = 12'h428
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic              fw_post,
    input logic              fw_consume,
    input logic              fw_hang,
    input logic              irq_fw,
    input logic              irq_host,
    input logic [1:0]        owner_q,
    input logic              hang_q,
    input logic              smi_en_q
);

    // R1: reset leaves the slot free and both interrupts low
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (owner_q == 2'd0 && !irq_fw && !irq_host && !hang_q));

    // R2: a held slot either stays with its owner or returns to free
    a_r2_claim_only_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q != 2'd0) |=> (owner_q == 2'd0 || $stable(owner_q)));

    // R7: consuming the inbound word drops the firmware interrupt
    a_r7_consume_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        fw_consume |=> !irq_fw);

    // R8: an accepted post with the host enable set raises the host interrupt
    a_r8_post_raises_host_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_post && owner_q != 2'd2 && smi_en_q && !(host_wr && host_addr == OFS_STAT))
        |=> irq_host);

    // R9: no host interrupt without its enable
    a_r9_host_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_host |-> smi_en_q);

    // R10: a hang pulse sets the sticky flag
    a_r10_hang_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        fw_hang |=> hang_q);

endmodule

bind hfw_mailbox hfw_mailbox_chk #(
    .ADDR_W   (ADDR_W),
    .OFS_STAT (OFS_STAT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .fw_post    (fw_post),
    .fw_consume (fw_consume),
    .fw_hang    (fw_hang),
    .irq_fw     (irq_fw),
    .irq_host   (irq_host),
    .owner_q    (owner_q),
    .hang_q     (hang_q),
    .smi_en_q   (smi_en_q)
);

// File: tb/hfw_mailbox_tb.sv
// Scoreboard bench: read tasks push expected words, a monitor pops and compares.
module hfw_mailbox_tb;

    localparam logic [11:0] A_CMD  = 12'h0E4;
    localparam logic [11:0] A_IN   = 12'h0E8;
    localparam logic [11:0] A_OUT  = 12'h0EC;
    localparam logic [11:0] A_OWN  = 12'h0F0;
    localparam logic [11:0] A_STAT = 12'h428;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        fw_post = 1'b0, fw_consume = 1'b0, fw_hang = 1'b0;
    logic [7:0]  fw_out_cmd = '0;
    logic [23:0] fw_out_data = '0;
    logic [7:0]  fw_in_cmd;
    logic [23:0] fw_in_data;
    logic        irq_fw, irq_host;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    hfw_mailbox u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .fw_post(fw_post), .fw_out_cmd(fw_out_cmd), .fw_out_data(fw_out_data),
        .fw_consume(fw_consume), .fw_hang(fw_hang), .fw_in_cmd(fw_in_cmd),
        .fw_in_data(fw_in_data), .irq_fw(irq_fw), .irq_host(irq_host)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: note a read strobe at the edge, compare at the following negedge
    always @(posedge clk) rd_seen <= host_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 32'h1, 32'h0);
            end else begin
                check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic host_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_write_hang(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d; fw_hang = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; fw_hang = 1'b0;
    endtask

    task automatic host_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic fw_do_post(input logic [7:0] c, input logic [23:0] d);
        @(negedge clk);
        fw_post = 1'b1; fw_out_cmd = c; fw_out_data = d;
        @(negedge clk);
        fw_post = 1'b0;
    endtask

    task automatic fw_do_consume();
        @(negedge clk);
        fw_consume = 1'b1;
        @(negedge clk);
        fw_consume = 1'b0;
    endtask

    task automatic fw_do_hang();
        @(negedge clk);
        fw_hang = 1'b1;
        @(negedge clk);
        fw_hang = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq_fw", {31'b0, irq_fw}, 32'h0);
        check("R1 irq_host", {31'b0, irq_host}, 32'h0);
        host_read(A_CMD,  32'h0, "R1 cmd");
        host_read(A_IN,   32'h0, "R1 inbound");
        host_read(A_OUT,  32'h0, "R1 outbound");
        host_read(A_OWN,  32'h0, "R1 owner");
        host_read(A_STAT, 32'h0, "R1 status");

        // R2 / R3: ownership
        host_write(A_OWN, 32'h2);
        host_read(A_OWN, 32'h2, "R2 host claims free slot");
        host_write(A_OWN, 32'h1);
        host_read(A_OWN, 32'h2, "R2 firmware claim while host owns");
        host_write(A_OWN, 32'h0);
        host_read(A_OWN, 32'h0, "R3 release from host");
        host_write(A_OWN, 32'h3);
        host_read(A_OWN, 32'h0, "R2 code 3 ignored");
        host_write(A_OWN, 32'h1);
        host_read(A_OWN, 32'h1, "R2 firmware claims free slot");
        host_write(A_OWN, 32'h0);
        host_read(A_OWN, 32'h0, "R3 release from firmware");

        // R4 / R5: inbound acceptance by owner
        host_write(A_IN, 32'h05ABCDEF);
        host_read(A_IN, 32'h0, "R4 write while free ignored");
        host_write(A_OWN, 32'h2);
        host_write(A_IN, 32'h05ABCDEF);
        host_read(A_IN, 32'h05ABCDEF, "R4 request with host owner");
        check("R5 fw_in_cmd", {24'b0, fw_in_cmd}, 32'h05);
        check("R5 fw_in_data", {8'b0, fw_in_data}, 32'hABCDEF);
        host_write(A_IN, 32'h80000001);
        host_read(A_IN, 32'h05ABCDEF, "R4 ACK with host owner ignored");
        host_write(A_OWN, 32'h0);
        host_write(A_OWN, 32'h1);
        host_write(A_IN, 32'h81123456);
        host_read(A_IN, 32'h81123456, "R4 NAK with firmware owner");
        check("R5 fw_in_cmd NAK", {24'b0, fw_in_cmd}, 32'h81);
        host_write(A_IN, 32'h02000000);
        host_read(A_IN, 32'h81123456, "R4 request with firmware owner ignored");

        // R6 / R7: command enables and firmware interrupt
        host_write(A_CMD, 32'h88000000);
        check("R6 irq_fw set", {31'b0, irq_fw}, 32'h1);
        host_read(A_CMD, 32'h88000000, "R6 cmd readback");
        host_write(A_CMD, 32'hFFFFFFFF);
        host_read(A_CMD, 32'hF8000000, "R6 low bits read 0");
        host_write(A_CMD, 32'h08000000);
        check("R6 no global enable", {31'b0, irq_fw}, 32'h0);
        host_write(A_CMD, 32'h88000000);
        fw_do_consume();
        check("R7 irq_fw after consume", {31'b0, irq_fw}, 32'h0);
        host_read(A_CMD, 32'h80000000, "R7 only bit 27 cleared");

        // R8 / R9: firmware post and host interrupt
        host_write(A_OWN, 32'h0);
        host_write(A_CMD, 32'h0);
        host_write(A_STAT, 32'h8);
        fw_do_post(8'h03, 24'h123456);
        check("R9 irq_host after post", {31'b0, irq_host}, 32'h1);
        check("R8 irq_fw stays low", {31'b0, irq_fw}, 32'h0);
        host_read(A_OUT, 32'h03123456, "R8 outbound packed");
        host_read(A_CMD, 32'hA0000000, "R8 bits 31 and 29 set");
        host_read(A_OWN, 32'h1, "R8 owner becomes firmware");
        host_write(A_CMD, 32'h80000000);
        check("R9 irq_host after bit 29 clear", {31'b0, irq_host}, 32'h0);
        host_write(A_OWN, 32'h0);
        host_read(A_OWN, 32'h0, "R3 host returns slot to idle");
        host_write(A_STAT, 32'h0);
        fw_do_post(8'h07, 24'h00BEEF);
        check("R9 irq_host gated by enable", {31'b0, irq_host}, 32'h0);
        host_read(A_CMD, 32'hA0000000, "R8 post with enable clear");
        host_write(A_OWN, 32'h0);
        host_write(A_OWN, 32'h2);
        fw_do_post(8'h06, 24'h000001);
        host_read(A_OUT, 32'h0700BEEF, "R8 post ignored while host owns");
        host_read(A_OWN, 32'h2, "R8 owner kept by host");

        // R10 / R11: hang flag
        host_write(A_OWN, 32'h0);
        host_write(A_CMD, 32'h0);
        host_write(A_STAT, 32'h8);
        fw_do_hang();
        host_read(A_STAT, 32'hA, "R10 hang flag set");
        check("R9 irq_host from hang", {31'b0, irq_host}, 32'h1);
        host_write(A_STAT, 32'h8);
        host_read(A_STAT, 32'hA, "R10 writing 0 keeps flag");
        host_write(A_STAT, 32'hA);
        host_read(A_STAT, 32'h8, "R10 write-back clears flag keeps enable");
        check("R9 irq_host after clear", {31'b0, irq_host}, 32'h0);
        host_write_hang(A_STAT, 32'hA);
        host_read(A_STAT, 32'hA, "R11 hang wins over clear");
        host_write(A_STAT, 32'hA);

        // R12: unmapped address
        host_write(12'h100, 32'hFFFFFFFF);
        host_read(12'h100, 32'h0, "R12 unmapped reads 0");
        host_read(A_CMD, 32'h0, "R12 cmd untouched");
        host_read(A_OWN, 32'h0, "R12 owner untouched");
        host_read(A_STAT, 32'h8, "R12 status untouched");

        @(negedge clk);
        check("scoreboard drained", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule